// File: doc/BRIEF.md
# Frame CRC scrubber with fault injection

The block is a background checker for a frame-organised configuration store. It visits frames in ascending order and wraps around. For each frame it takes a fixed number of data words from a valid/ready stream and folds them into a 16-bit CRC. It then compares the result with a signature that was written earlier into an internal table holding one entry per frame. The outcome of each comparison is latched on `crc_error`, and a one-cycle `frame_done` pulse marks the comparison. A per-frame exclusion mask marks frames that are not checked. The scanner steps over those frames in one cycle each and leaves `crc_error` unchanged.

A 21-bit injection register can be loaded serially to test the checker. A load is only taken while the device reports user mode and the presented instruction code selects the register. When the register is armed, its mask is XORed into the CRC of the next checked frame, which forces a mismatch on that frame alone.

Back-pressure rules: a word moves only in a cycle where both `in_valid` and `in_ready` are high. `in_ready` is high whenever the current frame is checked, and low while an excluded frame is being skipped. If `in_valid` stays low, the scan stalls on the current frame with no state change. The source supplies the words of the frame shown on `scan_frame`, in word order.

Top module: `frame_crc_scrubber`

## Requirements
- R1: The CRC uses polynomial 0x8005 and starts from zero for every frame. Each word is shifted in MSB first: for each bit, feedback = crc[15] XOR bit, crc shifts left by one, and the result is XORed with 0x8005 when feedback is 1. After the last word, `crc_error` goes to 1 exactly when the final CRC (XOR any applied injection mask) differs from the stored signature of that frame.
- R2: `crc_error` and `frame_done` change on the clock edge after the edge that accepts the last word of a checked frame. `frame_done` is high for that single cycle.
- R3: When `sig_we` is high at a clock edge, `sig_data` is written as the signature of frame `sig_addr`. Each frame has its own entry, which holds its value until it is rewritten.
- R4: For a frame whose bit is set in `excl_mask`, `in_ready` is low. The scanner moves on to the next frame after one cycle. That frame gives no `frame_done`, and `crc_error` keeps its previous value.
- R5: `scan_frame` steps from 0 up to NFRAMES-1 and then returns to 0. It advances only after the last word of a checked frame or after a skip.
- R6: A word is taken only when `in_valid` and `in_ready` are both high, and a frame takes exactly WORDS words. While `in_valid` is low on a checked frame, `scan_frame`, `crc_error` and `frame_done` do not move.
- R7: The injection register shifts left by one, taking `sh_din` into bit 0, only in a cycle where `sh_en` is high, `user_mode` is high and `sh_instr` equals 10'h015. Shift attempts outside user mode or with any other code leave the register unchanged. Loading a word therefore takes 21 shifts, most significant bit first.
- R8: Injection register fields are: bit 20 arms the injection, bits 19:16 are ignored, and bits 15:0 are the mask. When a checked frame completes while bit 20 is set and `user_mode` is high, the mask is XORed into that frame's CRC and bit 20 clears. If `user_mode` is low at that completion, nothing is applied and bit 20 stays set.
- R9: After reset, `crc_error`, `frame_done` and `scan_frame` are 0 and the injection register is all zero. The signature table has no reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| excl_mask | input | NFRAMES | One bit per frame; 1 skips that frame |
| scan_frame | output | clog2(NFRAMES) | Index of the frame being scanned |
| in_valid | input | 1 | Data word on `in_data` is valid |
| in_ready | output | 1 | Scanner can take a word this cycle |
| in_data | input | DATA_W | Data word of the current frame |
| sig_we | input | 1 | Signature write strobe |
| sig_addr | input | clog2(NFRAMES) | Frame whose signature is written |
| sig_data | input | 16 | Signature value |
| user_mode | input | 1 | Device is in user mode |
| sh_instr | input | 10 | Currently loaded instruction code |
| sh_en | input | 1 | Shift strobe for the injection register |
| sh_din | input | 1 | Serial data into the injection register |
| crc_error | output | 1 | Result of the last checked frame |
| frame_done | output | 1 | One-cycle pulse per completed comparison |

## Verification
The hardest case to reach is an injection that lands on one chosen frame while the scan keeps running. To get there, the bench stops driving `in_valid`, which parks the scanner on the target frame. It shifts in the armed mask at that point and then resumes the stream, so the target frame is the next one to complete. The bench sweeps this over every frame index and checks that only the target frame flags. To check that `crc_error` is held, the bench makes a frame flag an error just before a run of excluded frames. With the stream idle, it then watches each skip cycle until the scanner parks on the next checked frame.

// File: rtl/frame_crc_pkg.sv
package frame_crc_pkg;
  localparam int          CRC_W           = 16;
  localparam logic [15:0] CRC_POLY        = 16'h8005;
  localparam int          INJ_W           = 21;
  localparam int          INJ_ARM_BIT     = 20;
  localparam int          INJ_MASK_W      = 16;
  localparam int          INSTR_W         = 10;
  localparam logic [9:0]  INJ_SELECT_CODE = 10'h015;

  // One serial CRC step, MSB-first data.
  function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    crc_bit = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/crc16_engine.sv
module crc16_engine
  import frame_crc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              restart,
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  crc_nxt
);
  logic [CRC_W-1:0] crc_q;

  always_comb begin
    logic [CRC_W-1:0] acc;
    acc = crc_q;
    for (int i = DATA_W - 1; i >= 0; i--) acc = crc_bit(acc, data[i]);
    crc_nxt = acc;
  end

  // Accumulator returns to zero once a frame's last word is taken.
  always_ff @(posedge clk) begin
    if (!rst_n)  crc_q <= '0;
    else if (en) crc_q <= restart ? '0 : crc_nxt;
  end
endmodule

// File: rtl/sig_table.sv
module sig_table
  import frame_crc_pkg::*;
#(
  parameter int NFRAMES = 8,
  parameter int AW      = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [CRC_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [CRC_W-1:0] rdata
);
  logic [CRC_W-1:0] mem [NFRAMES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/inject_reg.sv
module inject_reg
  import frame_crc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  user_mode,
  input  logic                  sh_en,
  input  logic [INSTR_W-1:0]    sh_instr,
  input  logic                  sh_din,
  input  logic                  consume,
  output logic                  armed,
  output logic [INJ_MASK_W-1:0] mask
);
  logic [INJ_W-1:0] q;
  logic             sel;

  assign sel = user_mode && sh_en && (sh_instr == INJ_SELECT_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (sel)     q <= {q[INJ_W-2:0], sh_din};
    else if (consume) q[INJ_ARM_BIT] <= 1'b0;
  end

  assign armed = q[INJ_ARM_BIT];
  assign mask  = q[INJ_MASK_W-1:0];

  // R7: nothing changes the register outside user mode
  a_r7_user_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode |=> $stable(q));
  // R7: a foreign instruction code leaves the register alone
  a_r7_code_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_instr != INJ_SELECT_CODE && !consume) |=> $stable(q));
  // R8: arm bit clears after use
  a_r8_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !sh_en) |=> !armed);
endmodule

// File: rtl/frame_crc_scrubber.sv
module frame_crc_scrubber
  import frame_crc_pkg::*;
#(
  parameter int NFRAMES = 8,
  parameter int WORDS   = 4,
  parameter int DATA_W  = 16,
  localparam int FIDX_W = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NFRAMES-1:0] excl_mask,
  output logic [FIDX_W-1:0]  scan_frame,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               sig_we,
  input  logic [FIDX_W-1:0]  sig_addr,
  input  logic [CRC_W-1:0]   sig_data,
  input  logic               user_mode,
  input  logic [INSTR_W-1:0] sh_instr,
  input  logic               sh_en,
  input  logic               sh_din,
  output logic               crc_error,
  output logic               frame_done
);
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [FIDX_W-1:0] LAST_F = FIDX_W'(NFRAMES - 1);
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(WORDS - 1);

  logic [FIDX_W-1:0]     f_q;
  logic [WIDX_W-1:0]     w_q;
  logic                  err_q, done_q;
  logic                  cur_excl, acc, acc_last, advance;
  logic [CRC_W-1:0]      crc_nxt, sig_rd, applied;
  logic                  inj_armed, inj_live;
  logic [INJ_MASK_W-1:0] inj_mask;

  assign cur_excl = excl_mask[f_q];
  assign in_ready = !cur_excl;
  assign acc      = in_valid && in_ready;
  assign acc_last = acc && (w_q == LAST_W);
  assign advance  = cur_excl || acc_last;

  crc16_engine #(.DATA_W(DATA_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .en(acc), .restart(acc_last),
    .data(in_data), .crc_nxt(crc_nxt)
  );

  sig_table #(.NFRAMES(NFRAMES), .AW(FIDX_W)) u_sig (
    .clk(clk), .we(sig_we), .waddr(sig_addr), .wdata(sig_data),
    .raddr(f_q), .rdata(sig_rd)
  );

  assign inj_live = inj_armed && user_mode;

  inject_reg u_inj (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .sh_en(sh_en),
    .sh_instr(sh_instr), .sh_din(sh_din), .consume(acc_last && inj_live),
    .armed(inj_armed), .mask(inj_mask)
  );

  assign applied = inj_live ? inj_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_q    <= '0;
      w_q    <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= acc_last;
      if (acc_last) err_q <= ((crc_nxt ^ applied) != sig_rd);
      if (acc_last)  w_q <= '0;
      else if (acc)  w_q <= w_q + 1'b1;
      if (advance) f_q <= (f_q == LAST_F) ? '0 : f_q + 1'b1;
    end
  end

  assign scan_frame = f_q;
  assign crc_error  = err_q;
  assign frame_done = done_q;

  // R4: skipping an excluded frame holds the status
  a_r4_skip_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cur_excl |=> ($stable(crc_error) && !frame_done));
  // R2: completion pulse follows an accepted word
  a_r2_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(in_valid && in_ready));
  // R5: index stays within the frame count
  a_r5_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(scan_frame) < NFRAMES);
  // R6: an idle stream on a checked frame stalls the scan
  a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> ($stable(scan_frame) && $stable(crc_error) && !frame_done));
endmodule

// File: tb/test_frame_crc_scrubber.sv
`timescale 1ns/1ps
module test_frame_crc_scrubber;
  localparam int NF = 8;
  localparam int NW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NF-1:0] excl_mask = '0;
  logic [2:0]    scan_frame;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          sig_we = 1'b0;
  logic [2:0]    sig_addr = '0;
  logic [15:0]   sig_data = '0;
  logic          user_mode = 1'b1;
  logic [9:0]    sh_instr = '0;
  logic          sh_en = 1'b0;
  logic          sh_din = 1'b0;
  logic          crc_error, frame_done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  frame_crc_scrubber #(.NFRAMES(NF), .WORDS(NW), .DATA_W(DW)) i_frame_crc_scrubber (
    .clk(clk), .rst_n(rst_n), .excl_mask(excl_mask), .scan_frame(scan_frame),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .sig_we(sig_we), .sig_addr(sig_addr), .sig_data(sig_data),
    .user_mode(user_mode), .sh_instr(sh_instr), .sh_en(sh_en), .sh_din(sh_din),
    .crc_error(crc_error), .frame_done(frame_done)
  );

  function automatic logic [15:0] word_of(int f, int w);
    return 16'((f * 16'h1357) ^ (w * 16'h2468) ^ 16'hC0DE);
  endfunction

  function automatic logic [15:0] ref_crc(int f);
    logic [15:0] c = '0;
    for (int w = 0; w < NW; w++) begin
      logic [15:0] d = word_of(f, w);
      for (int b = 15; b >= 0; b--) begin
        logic top = c[15] ^ d[b];
        c = c << 1;
        if (top) c = c ^ 16'h8005;
      end
    end
    return c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_sig(int f, logic [15:0] v);
    @(negedge clk);
    sig_we = 1'b1; sig_addr = 3'(f); sig_data = v;
    @(negedge clk);
    sig_we = 1'b0;
  endtask

  // Shift 21 bits MSB first with the given code.
  task automatic shift_inj(logic [20:0] v, logic [9:0] code);
    for (int i = 20; i >= 0; i--) begin
      @(negedge clk);
      sh_en = 1'b1; sh_din = v[i]; sh_instr = code;
    end
    @(negedge clk);
    sh_en = 1'b0; sh_instr = '0;
  endtask

  // Feed one checked frame; report index, status and pulse after completion.
  task automatic run_frame(output int fr, output logic err, output logic done);
    int w = 0;
    fr = -1;
    while (w < NW) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = word_of(int'(scan_frame), w);
      if (in_ready) begin
        if (w == 0) fr = int'(scan_frame);
        w++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    err  = crc_error;
    done = frame_done;
  endtask

  task automatic advance_to(int t);
    int fr; logic e, d;
    @(negedge clk);
    while (int'(scan_frame) != t) run_frame(fr, e, d);
  endtask

  initial begin
    int fr; logic e, d;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(crc_error == 1'b0, "R9 crc_error", crc_error, 0);
    chk(frame_done == 1'b0, "R9 frame_done", frame_done, 0);
    chk(scan_frame == 3'd0, "R9 scan_frame", scan_frame, 0);
    rst_n = 1'b1;
    for (int f = 0; f < NF; f++) write_sig(f, ref_crc(f));
    // R6: idle stream, no movement
    repeat (3) @(negedge clk);
    chk(scan_frame == 3'd0 && !frame_done, "R6 stall", scan_frame, 0);

    // R1 R2 R5: two clean passes with wrap
    for (int i = 0; i < 2 * NF; i++) begin
      run_frame(fr, e, d);
      chk(fr == i % NF, "R5 order", fr, i % NF);
      chk(d == 1'b1, "R2 done pulse", d, 1);
      chk(e == 1'b0, "R1 clean crc", e, 0);
    end
    @(negedge clk);
    chk(frame_done == 1'b0, "R2 single pulse", frame_done, 0);

    // R3: corrupt one signature
    write_sig(5, ref_crc(5) ^ 16'h0001);
    for (int i = 0; i < NF; i++) begin
      run_frame(fr, e, d);
      chk(e == (fr == 5), "R3 signature mismatch", e, fr == 5);
    end
    write_sig(5, ref_crc(5));

    // R8: per-frame injection sweep
    for (int t = 0; t < NF; t++) begin
      advance_to(t);
      shift_inj({1'b1, 4'hF, 16'(16'h0101 << t)}, 10'h015);
      for (int i = 0; i < NF; i++) begin
        run_frame(fr, e, d);
        chk(e == (fr == t), "R8 injected frame only", e, fr == t);
      end
    end

    // R8: zero mask armed -> no error
    shift_inj({1'b1, 4'h0, 16'h0000}, 10'h015);
    run_frame(fr, e, d);
    chk(e == 1'b0, "R8 zero mask", e, 0);

    // R7: load attempt outside user mode ignored
    user_mode = 1'b0;
    shift_inj({1'b1, 4'h0, 16'hFFFF}, 10'h015);
    user_mode = 1'b1;
    for (int i = 0; i < NF; i++) begin
      run_frame(fr, e, d);
      chk(e == 1'b0, "R7 not user mode", e, 0);
    end
    // R7: wrong code ignored
    shift_inj({1'b1, 4'h0, 16'hFFFF}, 10'h014);
    for (int i = 0; i < NF; i++) begin
      run_frame(fr, e, d);
      chk(e == 1'b0, "R7 wrong code", e, 0);
    end
    // R7: armed word survives a foreign-code shift of zeros
    shift_inj({1'b1, 4'h0, 16'h8000}, 10'h015);
    shift_inj(21'h0, 10'h115);
    run_frame(fr, e, d);
    chk(e == 1'b1, "R7 register untouched", e, 1);
    run_frame(fr, e, d);
    chk(e == 1'b0, "R8 self clear", e, 0);

    // R8: completion outside user mode keeps the arm bit
    shift_inj({1'b1, 4'h0, 16'h0040}, 10'h015);
    user_mode = 1'b0;
    run_frame(fr, e, d);
    chk(e == 1'b0, "R8 not applied outside user mode", e, 0);
    user_mode = 1'b1;
    run_frame(fr, e, d);
    chk(e == 1'b1, "R8 applied later", e, 1);

    // R4: error before excluded frames is held while skipping
    advance_to(1);
    excl_mask = 8'b0001_1100;
    shift_inj({1'b1, 4'h0, 16'h0003}, 10'h015);
    run_frame(fr, e, d);
    chk(fr == 1 && e == 1'b1, "R4 setup error", e, 1);
    for (int k = 0; k < 3; k++) begin
      chk(scan_frame == 3'(2 + k) && !in_ready, "R4 skip step", scan_frame, 2 + k);
      chk(crc_error == 1'b1, "R4 status held", crc_error, 1);
      @(negedge clk);
      chk(frame_done == 1'b0, "R4 no done on skip", frame_done, 0);
    end
    repeat (2) @(negedge clk);
    chk(scan_frame == 3'd5 && in_ready, "R4 parks on checked", scan_frame, 5);
    chk(crc_error == 1'b1, "R4 status held at park", crc_error, 1);
    begin
      int exp_seq[5] = '{5, 6, 7, 0, 1};
      for (int i = 0; i < 5; i++) begin
        run_frame(fr, e, d);
        chk(fr == exp_seq[i], "R4 skip order", fr, exp_seq[i]);
        chk(e == 1'b0, "R4 clean after skip", e, 0);
      end
    end
    excl_mask = '0;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule